// File: doc/BRIEF.md
# DMA Channel Element Mover with Descriptor Chaining

This block does the data-moving work for one DMA channel after an arbiter has granted it. A start pulse hands it the channel's five working registers: source address, destination address, link pointer, control word and configuration word. The block then moves one element from the source address to the destination address over a simple request/acknowledge memory master port. It advances the addresses, decrements the remaining count held in the control word, and returns the updated register values together with a one-cycle done pulse. The channel logic writes those values back.

When the count reaches zero, the link pointer decides what happens next. If the link pointer is nonzero, the block fetches a four-word descriptor from it and reloads source, destination, link and control. If the link pointer is zero, the block clears the channel enable bit in the configuration word. A terminal-count flag pulses with done when the transfer that just finished asked for it.

An element has the width of the wider side. A narrow source is read several times and packed into one destination write. A narrow destination is written several times from one source read.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, mem_req and done are low, tc_flag is low and every register output reads zero.
- R2: A memory access holds mem_addr, mem_we, mem_size and, for writes, mem_wdata steady from the cycle mem_req rises until the cycle mem_ack is seen high. An access ends in that cycle. All reads of an element finish before its first write is issued.
- R3: Each element moved decrements control bits 11:0 by one. Control bits 31:12 come back unchanged, unless a descriptor reload replaces the whole word.
- R4: The source width is 1 << control[20:18] bytes and the destination width is 1 << control[23:21] bytes. Codes above 2 are treated as 2 (four bytes). mem_size carries the log2 byte count of each access, and descriptor reads use size 2.
- R5: The element size E is the larger of the two widths. With control bit 26 set, read i of an element goes to src+i*swidth and the source advances by E; with it clear, every read goes to src and the source stays. Control bit 27 does the same for writes and the destination, using dwidth.
- R6: Data is right-justified on the bus, and the lowest address is in bits 7:0. Read i fills element bytes i*swidth upward. Write j sends element bytes j*dwidth upward.
- R7: When the count reaches zero and the link pointer is zero, configuration bit 0 is cleared and the other configuration bits come back unchanged. No descriptor is read.
- R8: When the count reaches zero and the link pointer L is nonzero, four word reads follow the element, at L, L+4, L+8 and L+12 in that order. They load source from L, destination from L+4, link from L+8 and control from L+12. The configuration word comes back unchanged.
- R9: tc_flag pulses together with done when the count of the transfer just completed reached zero and that transfer's control bit 31 was set. Control bit 31 of a reloaded descriptor has no effect on this pulse.
- R10: done is high for exactly one cycle. It comes in the cycle after the acknowledge of the last write or, on a reload, of the last descriptor word. No memory request is active while done is high, and the register outputs hold their updated values from then until the next start.
- R11: A start with control bits 11:0 equal to zero makes no memory access. It gives done in the next cycle with all register outputs equal to the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Grant pulse; loads the register inputs when the block is idle |
| src_in | input | 32 | Channel source address |
| dst_in | input | 32 | Channel destination address |
| lnk_in | input | 32 | Channel link pointer |
| ctl_in | input | 32 | Channel control word |
| cfg_in | input | 32 | Channel configuration word |
| src_out | output | 32 | Updated source address |
| dst_out | output | 32 | Updated destination address |
| lnk_out | output | 32 | Updated link pointer |
| ctl_out | output | 32 | Updated control word |
| cfg_out | output | 32 | Updated configuration word |
| done | output | 1 | One-cycle completion pulse |
| tc_flag | output | 1 | Terminal-count pulse, high only with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | log2 of the access byte count |
| mem_wdata | output | 32 | Right-justified write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Right-justified read data, valid with mem_ack |

## Verification
The bench goes after width mismatches in both directions. A packer that fills the wrong byte lanes shows up as a scrambled destination word. An unpacker that reuses lane zero writes the same byte four times. It drives count-one transfers with and without a link pointer. A design that skips the reload, fetches the words in the wrong order or swaps the link and control slots returns wrong register values. Clearing the enable bit on a chained transfer, or taking the terminal-count bit from the reloaded descriptor, also fails there. Further tests cover zero-count starts, disabled increments, out-of-range width codes and a slow memory. These catch an engine that touches memory when it should not, steps addresses it should hold, or drops a request before its acknowledge.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int MAX_LOG    = $clog2(LANES);
  localparam int SZ_W       = $clog2(MAX_LOG + 1);
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2((LANES > DESC_WORDS) ? LANES : DESC_WORDS);

  // control word fields
  localparam int CNT_W      = 12;
  localparam int SW_LSB     = 18;
  localparam int DW_LSB     = 21;
  localparam int CODE_W     = 3;
  localparam int SINC_BIT   = 26;
  localparam int DINC_BIT   = 27;
  localparam int TC_BIT     = 31;
  // configuration word fields
  localparam int EN_BIT     = 0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_DESC  = 3'd3,
    ST_FIN   = 3'd4
  } xfer_state_e;

  function automatic logic [SZ_W-1:0] clamp_log(input logic [CODE_W-1:0] code);
    if (int'(code) > MAX_LOG) return SZ_W'(MAX_LOG);
    return SZ_W'(code);
  endfunction
endpackage

// File: rtl/dma_beat_plan.sv
module dma_beat_plan
  import dma_xfer_pkg::*;
(
  input  logic [WORD_W-1:0] ctl,
  output logic [SZ_W-1:0]   sw_log,
  output logic [SZ_W-1:0]   dw_log,
  output logic [SZ_W-1:0]   elem_log,
  output logic [IDX_W-1:0]  rd_last,
  output logic [IDX_W-1:0]  wr_last
);
  always_comb begin
    sw_log   = clamp_log(ctl[SW_LSB +: CODE_W]);
    dw_log   = clamp_log(ctl[DW_LSB +: CODE_W]);
    elem_log = (sw_log > dw_log) ? sw_log : dw_log;
    rd_last  = IDX_W'((1 << (elem_log - sw_log)) - 1);
    wr_last  = IDX_W'((1 << (elem_log - dw_log)) - 1);
  end
endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf
  import dma_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic [SZ_W-1:0]   sw_log,
  input  logic [SZ_W-1:0]   dw_log,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] wdata
);
  logic [LANES-1:0][7:0] buf_q;
  logic [LANES-1:0][7:0] buf_d;
  logic [LANES-1:0][7:0] rd_lanes;
  logic [LANES-1:0][7:0] wr_lanes;

  assign rd_lanes = rdata;

  always_comb begin
    int base;
    int span;
    buf_d = buf_q;
    base  = int'(slot_idx) << sw_log;
    span  = 1 << sw_log;
    for (int b = 0; b < LANES; b++) begin
      if (b >= base && b < base + span) buf_d[b] = rd_lanes[b - base];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_q <= '0;
    else if (load_en) buf_q <= buf_d;
  end

  always_comb begin
    int base;
    int span;
    base = int'(slot_idx) << dw_log;
    span = 1 << dw_log;
    for (int b = 0; b < LANES; b++) begin
      wr_lanes[b] = 8'h00;
      if (b < span && (b + base) < LANES) wr_lanes[b] = buf_q[b + base];
    end
  end

  assign wdata = wr_lanes;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  xfer_state_e       state,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] lnk,
  input  logic              src_inc,
  input  logic              dst_inc,
  input  logic [SZ_W-1:0]   sw_log,
  input  logic [SZ_W-1:0]   dw_log,
  input  logic [SZ_W-1:0]   elem_log,
  output logic [ADDR_W-1:0] addr,
  output logic [SZ_W-1:0]   size,
  output logic [ADDR_W-1:0] src_next,
  output logic [ADDR_W-1:0] dst_next
);
  localparam int WORD_LOG = $clog2(WORD_W / 8);

  logic [ADDR_W-1:0] idx_w;
  logic [ADDR_W-1:0] elem_bytes;

  assign idx_w      = ADDR_W'(idx);
  assign elem_bytes = ADDR_W'(1) << elem_log;

  always_comb begin
    addr = '0;
    size = '0;
    case (state)
      ST_READ: begin
        addr = src_inc ? (src + (idx_w << sw_log)) : src;
        size = sw_log;
      end
      ST_WRITE: begin
        addr = dst_inc ? (dst + (idx_w << dw_log)) : dst;
        size = dw_log;
      end
      ST_DESC: begin
        addr = lnk + (idx_w << WORD_LOG);
        size = SZ_W'(WORD_LOG);
      end
      default: ;
    endcase
  end

  assign src_next = src_inc ? (src + elem_bytes) : src;
  assign dst_next = dst_inc ? (dst + elem_bytes) : dst;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_cnt_zero,
  input  logic             mem_ack,
  input  logic [IDX_W-1:0] rd_last,
  input  logic [IDX_W-1:0] wr_last,
  input  logic             cnt_one,
  input  logic             lnk_zero,
  input  logic             tc_req,
  output xfer_state_e      state,
  output logic [IDX_W-1:0] idx,
  output logic             load_regs,
  output logic             buf_load,
  output logic             elem_commit,
  output logic             desc_load,
  output logic             done_pulse,
  output logic             tc_pulse
);
  localparam logic [IDX_W-1:0] DESC_LAST = IDX_W'(DESC_WORDS - 1);

  xfer_state_e      state_d;
  logic [IDX_W-1:0] idx_d;
  logic             tc_q;
  logic             tc_d;

  always_comb begin
    state_d     = state;
    idx_d       = idx;
    tc_d        = tc_q;
    load_regs   = 1'b0;
    buf_load    = 1'b0;
    elem_commit = 1'b0;
    desc_load   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          load_regs = 1'b1;
          tc_d      = 1'b0;
          idx_d     = '0;
          state_d   = start_cnt_zero ? ST_FIN : ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          buf_load = 1'b1;
          if (idx == rd_last) begin
            idx_d   = '0;
            state_d = ST_WRITE;
          end else begin
            idx_d = idx + 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (idx == wr_last) begin
            elem_commit = 1'b1;
            idx_d       = '0;
            tc_d        = cnt_one & tc_req;
            state_d     = (cnt_one && !lnk_zero) ? ST_DESC : ST_FIN;
          end else begin
            idx_d = idx + 1'b1;
          end
        end
      end
      ST_DESC: begin
        if (mem_ack) begin
          desc_load = 1'b1;
          if (idx == DESC_LAST) begin
            idx_d   = '0;
            state_d = ST_FIN;
          end else begin
            idx_d = idx + 1'b1;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      tc_q  <= 1'b0;
    end else begin
      state <= state_d;
      idx   <= idx_d;
      tc_q  <= tc_d;
    end
  end

  assign done_pulse = (state == ST_FIN);
  assign tc_pulse   = (state == ST_FIN) & tc_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [ADDR_W-1:0] lnk_in,
  input  logic [WORD_W-1:0] ctl_in,
  input  logic [WORD_W-1:0] cfg_in,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [ADDR_W-1:0] lnk_out,
  output logic [WORD_W-1:0] ctl_out,
  output logic [WORD_W-1:0] cfg_out,
  output logic              done,
  output logic              tc_flag,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SZ_W-1:0]   mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic [ADDR_W-1:0] src_q, dst_q, lnk_q, lnk_tmp_q;
  logic [WORD_W-1:0] ctl_q, cfg_q;
  logic [ADDR_W-1:0] src_d, dst_d, lnk_d, lnk_tmp_d;
  logic [WORD_W-1:0] ctl_d, cfg_d;

  xfer_state_e      state;
  logic [IDX_W-1:0] idx;
  logic [SZ_W-1:0]  sw_log, dw_log, elem_log;
  logic [IDX_W-1:0] rd_last, wr_last;
  logic             load_regs, buf_load, elem_commit, desc_load;
  logic             cnt_one, lnk_zero, start_cnt_zero;
  logic [ADDR_W-1:0] src_next, dst_next;

  assign cnt_one        = (ctl_q[CNT_W-1:0] == CNT_W'(1));
  assign lnk_zero       = (lnk_q == '0);
  assign start_cnt_zero = (ctl_in[CNT_W-1:0] == '0);

  dma_beat_plan i_plan (
    .ctl      (ctl_q),
    .sw_log   (sw_log),
    .dw_log   (dw_log),
    .elem_log (elem_log),
    .rd_last  (rd_last),
    .wr_last  (wr_last)
  );

  dma_xfer_fsm i_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_cnt_zero (start_cnt_zero),
    .mem_ack        (mem_ack),
    .rd_last        (rd_last),
    .wr_last        (wr_last),
    .cnt_one        (cnt_one),
    .lnk_zero       (lnk_zero),
    .tc_req         (ctl_q[TC_BIT]),
    .state          (state),
    .idx            (idx),
    .load_regs      (load_regs),
    .buf_load       (buf_load),
    .elem_commit    (elem_commit),
    .desc_load      (desc_load),
    .done_pulse     (done),
    .tc_pulse       (tc_flag)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .state    (state),
    .idx      (idx),
    .src      (src_q),
    .dst      (dst_q),
    .lnk      (lnk_q),
    .src_inc  (ctl_q[SINC_BIT]),
    .dst_inc  (ctl_q[DINC_BIT]),
    .sw_log   (sw_log),
    .dw_log   (dw_log),
    .elem_log (elem_log),
    .addr     (mem_addr),
    .size     (mem_size),
    .src_next (src_next),
    .dst_next (dst_next)
  );

  dma_pack_buf i_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (buf_load),
    .slot_idx (idx),
    .sw_log   (sw_log),
    .dw_log   (dw_log),
    .rdata    (mem_rdata),
    .wdata    (mem_wdata)
  );

  assign mem_req = (state == ST_READ) || (state == ST_WRITE) || (state == ST_DESC);
  assign mem_we  = (state == ST_WRITE);

  always_comb begin
    src_d     = src_q;
    dst_d     = dst_q;
    lnk_d     = lnk_q;
    ctl_d     = ctl_q;
    cfg_d     = cfg_q;
    lnk_tmp_d = lnk_tmp_q;
    if (load_regs) begin
      src_d = src_in;
      dst_d = dst_in;
      lnk_d = lnk_in;
      ctl_d = ctl_in;
      cfg_d = cfg_in;
    end else if (elem_commit) begin
      src_d              = src_next;
      dst_d              = dst_next;
      ctl_d[CNT_W-1:0]   = ctl_q[CNT_W-1:0] - CNT_W'(1);
      if (cnt_one && lnk_zero) cfg_d[EN_BIT] = 1'b0;
    end else if (desc_load) begin
      case (idx)
        IDX_W'(0): src_d     = ADDR_W'(mem_rdata);
        IDX_W'(1): dst_d     = ADDR_W'(mem_rdata);
        IDX_W'(2): lnk_tmp_d = ADDR_W'(mem_rdata);
        default: begin
          ctl_d = mem_rdata;
          lnk_d = lnk_tmp_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      dst_q     <= '0;
      lnk_q     <= '0;
      ctl_q     <= '0;
      cfg_q     <= '0;
      lnk_tmp_q <= '0;
    end else if (load_regs || elem_commit || desc_load) begin
      src_q     <= src_d;
      dst_q     <= dst_d;
      lnk_q     <= lnk_d;
      ctl_q     <= ctl_d;
      cfg_q     <= cfg_d;
      lnk_tmp_q <= lnk_tmp_d;
    end
  end

  assign src_out = src_q;
  assign dst_out = dst_q;
  assign lnk_out = lnk_q;
  assign ctl_out = ctl_q;
  assign cfg_out = cfg_q;
endmodule

// File: rtl/dma_xfer_checker.sv
module dma_xfer_checker
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              tc_flag,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SZ_W-1:0]   mem_size,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ack
);
  // R2: an access stays put until it is acknowledged
  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_size) && (!mem_we || $stable(mem_wdata))));

  // R4: no access is wider than a bus word
  p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_size) <= MAX_LOG));

  // R9: terminal count only together with completion
  p_tc_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_flag |-> done);

  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: no request is open while done is shown
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R10, R11: done follows an acknowledge or a start
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_ack) || $past(start)));
endmodule

bind dma_xfer_engine dma_xfer_checker #(.ADDR_W(ADDR_W)) i_dma_xfer_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .tc_flag   (tc_flag),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/test_dma_xfer_engine.sv
`timescale 1ns/1ps
module test_dma_xfer_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_in = '0, dst_in = '0, lnk_in = '0, ctl_in = '0, cfg_in = '0;
  logic [31:0] src_out, dst_out, lnk_out, ctl_out, cfg_out;
  logic        done, tc_flag, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int wait_cnt = 0;
  int acc_cnt = 0;
  int base = 0;
  int n_acc = 0;
  logic        tc_seen;
  logic [7:0]  mem [0:1023];
  logic [31:0] log_addr [0:63];
  logic        log_we   [0:63];
  logic [1:0]  log_size [0:63];

  always #4 clk = ~clk;

  dma_xfer_engine i_dma_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_in(src_in), .dst_in(dst_in), .lnk_in(lnk_in), .ctl_in(ctl_in), .cfg_in(cfg_in),
    .src_out(src_out), .dst_out(dst_out), .lnk_out(lnk_out), .ctl_out(ctl_out), .cfg_out(cfg_out),
    .done(done), .tc_flag(tc_flag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: answers on the falling edge, after lat waiting cycles
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack <= 1'b1;
        wait_cnt = 0;
        if (acc_cnt < 64) begin
          log_addr[acc_cnt] = mem_addr;
          log_we[acc_cnt]   = mem_we;
          log_size[acc_cnt] = mem_size;
        end
        acc_cnt = acc_cnt + 1;
        if (mem_we) begin
          for (int b = 0; b < (1 << mem_size); b++)
            mem[(mem_addr + b) & 32'h3ff] = mem_wdata[8*b +: 8];
          mem_rdata <= '0;
        end else begin
          logic [31:0] v;
          v = '0;
          for (int b = 0; b < (1 << mem_size); b++)
            v[8*b +: 8] = mem[(mem_addr + b) & 32'h3ff];
          mem_rdata <= v;
        end
      end else begin
        mem_ack <= 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) mem[(a + b) & 32'h3ff] = w[8*b +: 8];
  endtask

  function automatic logic [31:0] get_word(input int a);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) w[8*b +: 8] = mem[(a + b) & 32'h3ff];
    return w;
  endfunction

  task automatic run_xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                          input logic [31:0] c, input logic [31:0] f);
    int n;
    @(negedge clk);
    base = acc_cnt;
    src_in = s; dst_in = d; lnk_in = l; ctl_in = c; cfg_in = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", {31'd0, done}, 32'd1);
    tc_seen = tc_flag;
    n_acc = acc_cnt - base;
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 src_out", src_out, 0);
    chk("R1 ctl_out", ctl_out, 0);
    chk("R1 cfg_out", cfg_out, 0);
    chk("R1 idle", {29'd0, mem_req, done, tc_flag}, 0);
  endtask

  task automatic t_byte_inc;
    mem[12'h100] = 8'hA5;
    mem[12'h200] = 8'h00;
    run_xfer(32'h100, 32'h200, 32'h0, 32'h4C00_3005, 32'h0000_C0A1);
    chk("R3 count down upper kept", ctl_out, 32'h4C00_3004);
    chk("R5 src step", src_out, 32'h101);
    chk("R5 dst step", dst_out, 32'h201);
    chk("R6 byte moved", {24'd0, mem[12'h200]}, 32'hA5);
    chk("R2 two accesses", n_acc, 2);
    chk("R9 no tc", {31'd0, tc_seen}, 0);
    chk("R7 cfg unchanged", cfg_out, 32'h0000_C0A1);
  endtask

  task automatic t_word_hold;
    put_word(32'h110, 32'h4433_2211);
    put_word(32'h210, 32'h0);
    run_xfer(32'h110, 32'h210, 32'h0, 32'h0048_0003, 32'h1);
    chk("R5 src held", src_out, 32'h110);
    chk("R5 dst held", dst_out, 32'h210);
    chk("R3 count", ctl_out, 32'h0048_0002);
    chk("R6 word moved", get_word(32'h210), 32'h4433_2211);
    chk("R4 read size", {30'd0, log_size[base]}, 2);
    chk("R2 read then write", {30'd0, log_we[base], log_we[base+1]}, 32'b01);
  endtask

  task automatic t_pack(input int l);
    lat = l;
    put_word(32'h120, 32'hEFBE_ADDE);
    put_word(32'h220, 32'h0);
    run_xfer(32'h120, 32'h220, 32'h0, 32'h0C40_0002, 32'h1);
    chk("R6 packed word", get_word(32'h220), 32'hEFBE_ADDE);
    chk("R2 pack accesses", n_acc, 5);
    for (int i = 0; i < 4; i++) begin
      chk("R5 read address", log_addr[base+i], 32'h120 + i);
      chk("R2 reads first", {31'd0, log_we[base+i]}, 0);
    end
    chk("R2 final write", {31'd0, log_we[base+4]}, 1);
    chk("R5 src by element", src_out, 32'h124);
    chk("R5 dst by element", dst_out, 32'h224);
    chk("R3 pack count", ctl_out, 32'h0C40_0001);
    lat = 0;
  endtask

  task automatic t_unpack;
    put_word(32'h130, 32'h0403_0201);
    put_word(32'h230, 32'h0);
    run_xfer(32'h130, 32'h230, 32'h0, 32'h0C08_0003, 32'h1);
    chk("R2 unpack accesses", n_acc, 5);
    for (int j = 0; j < 4; j++) begin
      chk("R5 write address", log_addr[base+1+j], 32'h230 + j);
      chk("R4 byte size", {30'd0, log_size[base+1+j]}, 0);
    end
    chk("R6 unpacked bytes", get_word(32'h230), 32'h0403_0201);
    chk("R5 unpack src", src_out, 32'h134);
    chk("R5 unpack dst", dst_out, 32'h234);
  endtask

  task automatic t_half_clamp;
    put_word(32'h140, 32'h1312_1110);
    put_word(32'h240, 32'h0);
    run_xfer(32'h140, 32'h240, 32'h0, 32'h04E4_0004, 32'h1);
    chk("R4 half reads", n_acc, 3);
    chk("R4 half size", {30'd0, log_size[base]}, 1);
    chk("R5 second half addr", log_addr[base+1], 32'h142);
    chk("R4 clamped size", {30'd0, log_size[base+2]}, 2);
    chk("R6 half pack", get_word(32'h240), 32'h1312_1110);
    chk("R5 src only", src_out, 32'h144);
    chk("R5 dst kept", dst_out, 32'h240);
  endtask

  task automatic t_end_no_link;
    mem[12'h150] = 8'h5A;
    run_xfer(32'h150, 32'h250, 32'h0, 32'h8C00_0001, 32'h0000_C0A1);
    chk("R7 enable cleared", cfg_out, 32'h0000_C0A0);
    chk("R3 count zero", ctl_out, 32'h8C00_0000);
    chk("R9 tc set", {31'd0, tc_seen}, 1);
    chk("R7 no descriptor", n_acc, 2);
  endtask

  task automatic t_link_reload;
    mem[12'h160] = 8'h77;
    put_word(32'h300, 32'h0000_0170);
    put_word(32'h304, 32'h0000_0270);
    put_word(32'h308, 32'h0000_0340);
    put_word(32'h30C, 32'h8C00_0007);
    run_xfer(32'h160, 32'h260, 32'h300, 32'h0C00_0001, 32'h0000_C0A1);
    chk("R8 accesses", n_acc, 6);
    for (int k = 0; k < 4; k++) begin
      chk("R8 desc address", log_addr[base+2+k], 32'h300 + 4*k);
      chk("R8 desc size", {30'd0, log_size[base+2+k]}, 2);
    end
    chk("R8 src reload", src_out, 32'h170);
    chk("R8 dst reload", dst_out, 32'h270);
    chk("R8 link reload", lnk_out, 32'h340);
    chk("R8 ctl reload", ctl_out, 32'h8C00_0007);
    chk("R8 cfg kept", cfg_out, 32'h0000_C0A1);
    chk("R9 old tc bit rules", {31'd0, tc_seen}, 0);
  endtask

  task automatic t_zero_count;
    run_xfer(32'h180, 32'h280, 32'h390, 32'h8C00_0000, 32'h0000_00F1);
    chk("R11 no access", n_acc, 0);
    chk("R11 src", src_out, 32'h180);
    chk("R11 dst", dst_out, 32'h280);
    chk("R11 lnk", lnk_out, 32'h390);
    chk("R11 ctl", ctl_out, 32'h8C00_0000);
    chk("R11 cfg", cfg_out, 32'h0000_00F1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_inc();
    t_word_hold();
    t_pack(0);
    t_unpack();
    t_half_clamp();
    t_end_no_link();
    t_link_reload();
    t_zero_count();
    t_pack(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule